// File: doc/BRIEF.md
# Signed Multiply/Divide Unit

This unit performs signed integer arithmetic for a word-oriented stack machine. It takes up to three stack words as operands: the top word, the second word and the third word. It runs one of four operations: a short multiply, a long multiply, a long divide and a short divide. It returns two result words with an overflow flag and a divide-by-zero trap flag. A single-cycle done pulse marks the result.

The caller raises `start` for one cycle while the unit is idle. The unit captures the operation code and all three operands on that edge and raises `busy`. When `done` pulses, the caller writes `resTop` to the top of the stack and `resSecond` to the word below it. Both multiplies finish quickly. Both divides use a restoring shift-subtract loop of one step per dividend bit. A zero divisor, or a long divide whose overflow can be seen in advance, skips that loop.

Top module: `mdu_top`

## Requirements
- R1: After reset `busy`, `done`, `ovf`, `divZero`, `resTop` and `resSecond` are all 0.
- R2: `start` is taken only while `busy` is low. The operation and all three operands are captured on that edge. Later changes to the operand inputs, to `opSel`, or further `start` pulses while `busy` is high do not affect the result.
- R3: `busy` is high from the cycle after an accepted start up to and including the cycle in which `done` is high. `done` is high for exactly one cycle, and `busy` is low in the cycle after it.
- R4: Counting clock edges from the edge that accepts `start`, `done` is high after 2 edges for both multiplies, for a zero divisor and for a predicted long-divide overflow. It is high after 2*WIDTH+3 edges for a divide that iterates.
- R5: `opSel` encoding: 0 = short multiply, 1 = long multiply, 2 = long divide, 3 = short divide.
- R6: Short multiply: the sign-extended `tosA` times `tosB` forms a 2*WIDTH-bit signed product. `resTop` is its low WIDTH bits and `resSecond` is 0. `ovf` is 1 unless the upper WIDTH+1 product bits are all equal.
- R7: Long multiply: `resSecond` holds the upper WIDTH bits and `resTop` the lower WIDTH bits of the signed product. `ovf` and `divZero` are 0.
- R8: For either divide with `tosA` equal to 0, `divZero` is 1, `ovf` is 0, and both result words are 0.
- R9: Long divide: the dividend is the signed 2*WIDTH-bit value {`tosC`,`tosB`} and the divisor is the sign-extended `tosA`. The quotient goes to `resTop` and the remainder to `resSecond`.
- R10: Long divide with a nonzero divisor whose magnitude is less than or equal to the magnitude of the sign-extended `tosC` sets `ovf` to 1. Both result words are then 0 and no iteration takes place.
- R11: When a divide that iterates yields a quotient outside the signed WIDTH-bit range, `ovf` is 1. `resTop` holds the low WIDTH bits of the quotient and `resSecond` the remainder. Otherwise `ovf` is 0.
- R12: Short divide: the sign-extended `tosB` is divided by the sign-extended `tosA`. The quotient truncates toward zero and goes to `resTop`. The remainder goes to `resSecond` and is either zero or has the sign of the dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only while idle) |
| opSel | input | 2 | Operation code, see R5 |
| tosA | input | WIDTH | Top stack word: multiplier or divisor |
| tosB | input | WIDTH | Second stack word: multiplicand, short dividend or low dividend half |
| tosC | input | WIDTH | Third stack word: high dividend half for the long divide |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| resTop | output | WIDTH | Word for the top of the stack |
| resSecond | output | WIDTH | Word for the second stack position |
| ovf | output | 1 | Arithmetic overflow |
| divZero | output | 1 | Integer divide-by-zero trap |

## Verification
The assertions assume that reset is applied before the first `start`. They also assume that `opSel` is a defined 2-bit code whenever `start` is high, so the control never latches an unknown operation. The bench uses a 4-bit configuration, which makes every input legal. It sweeps every operand pair for the multiplies and the short divide, and every operand triple for the long divide. It deliberately raises `start` again and inverts all operand inputs while each operation is busy. This exercises the capture rule without ever leaving the defined input space.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    OP_MULS = 2'd0,
    OP_MULL = 2'd1,
    OP_DIVL = 2'd2,
    OP_DIVS = 2'd3
  } mduOp_e;

  typedef struct packed {
    mduOp_e op;
    logic   load;
    logic   evalMul;
    logic   initDiv;
    logic   stepDiv;
    logic   finish;
    logic   trapZero;
    logic   trapOvf;
  } mduStrobe_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  mduOp_e     opIn,
  input  logic       dvsZero,
  input  logic       earlyOvf,
  output mduStrobe_t stb,
  output logic       busy,
  output logic       done
);

  localparam int STEPS = 2 * WIDTH;
  localparam int CW    = $clog2(STEPS);

  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_ITER, S_FIN, S_DONE} state_e;

  state_e          state, stateNxt;
  mduOp_e          opReg;
  logic [CW-1:0]   cnt;
  logic            lastStep;
  logic            isMul;

  assign lastStep = (cnt == CW'(STEPS - 1));
  assign isMul    = (opReg == OP_MULS) || (opReg == OP_MULL);

  always_comb begin
    stateNxt     = state;
    stb          = '0;
    stb.op       = opReg;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          stb.load = 1'b1;
          stateNxt = S_EVAL;
        end
      end
      S_EVAL: begin
        if (isMul) begin
          stb.evalMul = 1'b1;
          stateNxt    = S_DONE;
        end else if (dvsZero) begin
          stb.trapZero = 1'b1;
          stateNxt     = S_DONE;
        end else if (opReg == OP_DIVL && earlyOvf) begin
          stb.trapOvf = 1'b1;
          stateNxt    = S_DONE;
        end else begin
          stb.initDiv = 1'b1;
          stateNxt    = S_ITER;
        end
      end
      S_ITER: begin
        stb.stepDiv = 1'b1;
        if (lastStep) stateNxt = S_FIN;
      end
      S_FIN: begin
        stb.finish = 1'b1;
        stateNxt   = S_DONE;
      end
      S_DONE:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      opReg <= OP_MULS;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      if (state == S_IDLE && start) opReg <= opIn;
      if (stb.initDiv)      cnt <= '0;
      else if (stb.stepDiv) cnt <= cnt + CW'(1);
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R2
  op_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> $stable(opReg));

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  mduStrobe_t       stb,
  input  logic [WIDTH-1:0] tosA,
  input  logic [WIDTH-1:0] tosB,
  input  logic [WIDTH-1:0] tosC,
  output logic             dvsZero,
  output logic             earlyOvf,
  output logic [WIDTH-1:0] resTop,
  output logic [WIDTH-1:0] resSecond,
  output logic             ovf,
  output logic             divZero
);

  localparam int DW = 2 * WIDTH;

  logic [WIDTH-1:0] aReg, bReg, cReg;

  // multiply
  logic signed [DW-1:0] product;
  logic [WIDTH:0]       prodUpper;
  logic                 mulOvf;

  assign product   = $signed(aReg) * $signed(bReg);
  assign prodUpper = product[DW-1:WIDTH-1];
  assign mulOvf    = !((&prodUpper) || (~|prodUpper));

  // divide operand preparation
  logic [DW-1:0]  dvdFull, dvdMag;
  logic           dvdNeg, dvsNeg;
  logic [WIDTH:0] dvsExt, dvsMag, cExt, cMag;

  assign dvdFull = (stb.op == OP_DIVL) ? {cReg, bReg} : {{WIDTH{bReg[WIDTH-1]}}, bReg};
  assign dvdNeg  = dvdFull[DW-1];
  assign dvdMag  = dvdNeg ? (~dvdFull + DW'(1)) : dvdFull;
  assign dvsExt  = {aReg[WIDTH-1], aReg};
  assign dvsNeg  = aReg[WIDTH-1];
  assign dvsMag  = dvsNeg ? (~dvsExt + (WIDTH+1)'(1)) : dvsExt;
  assign cExt    = {cReg[WIDTH-1], cReg};
  assign cMag    = cReg[WIDTH-1] ? (~cExt + (WIDTH+1)'(1)) : cExt;
  assign dvsZero  = (aReg == '0);
  assign earlyOvf = (dvsMag <= cMag);

  // restoring divider state
  logic [WIDTH:0]   remR, magD;
  logic [DW-1:0]    quoR;
  logic             qNegR, rNegR;
  logic [WIDTH+1:0] shifted, trial;

  assign shifted = {remR, quoR[DW-1]};
  assign trial   = shifted - {1'b0, magD};

  // final sign application
  logic [DW:0]    qMagExt, qSigned;
  logic [WIDTH:0] rSigned;
  logic           qFits;

  assign qMagExt = {1'b0, quoR};
  assign qSigned = qNegR ? (~qMagExt + (DW+1)'(1)) : qMagExt;
  assign rSigned = rNegR ? (~remR + (WIDTH+1)'(1)) : remR;
  assign qFits   = (&qSigned[DW:WIDTH-1]) || (~|qSigned[DW:WIDTH-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg      <= '0;
      bReg      <= '0;
      cReg      <= '0;
      remR      <= '0;
      magD      <= '0;
      quoR      <= '0;
      qNegR     <= 1'b0;
      rNegR     <= 1'b0;
      resTop    <= '0;
      resSecond <= '0;
      ovf       <= 1'b0;
      divZero   <= 1'b0;
    end else begin
      if (stb.load) begin
        aReg <= tosA;
        bReg <= tosB;
        cReg <= tosC;
      end
      if (stb.evalMul) begin
        resTop  <= product[WIDTH-1:0];
        divZero <= 1'b0;
        if (stb.op == OP_MULL) begin
          resSecond <= product[DW-1:WIDTH];
          ovf       <= 1'b0;
        end else begin
          resSecond <= '0;
          ovf       <= mulOvf;
        end
      end
      if (stb.trapZero) begin
        resTop    <= '0;
        resSecond <= '0;
        ovf       <= 1'b0;
        divZero   <= 1'b1;
      end
      if (stb.trapOvf) begin
        resTop    <= '0;
        resSecond <= '0;
        ovf       <= 1'b1;
        divZero   <= 1'b0;
      end
      if (stb.initDiv) begin
        remR  <= '0;
        quoR  <= dvdMag;
        magD  <= dvsMag;
        qNegR <= dvdNeg ^ dvsNeg;
        rNegR <= dvdNeg;
      end
      if (stb.stepDiv) begin
        if (!trial[WIDTH+1]) begin
          remR <= trial[WIDTH:0];
          quoR <= {quoR[DW-2:0], 1'b1};
        end else begin
          remR <= shifted[WIDTH:0];
          quoR <= {quoR[DW-2:0], 1'b0};
        end
      end
      if (stb.finish) begin
        resTop    <= qSigned[WIDTH-1:0];
        resSecond <= rSigned[WIDTH-1:0];
        ovf       <= !qFits;
        divZero   <= 1'b0;
      end
    end
  end

  // R8
  divzero_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    divZero |-> (resTop == '0 && resSecond == '0 && !ovf));

  // R7
  long_mul_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.evalMul && stb.op == OP_MULL) |=> (!ovf && !divZero));

  // R12
  rem_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finish && rNegR != rSigned[WIDTH-1] && rSigned != '0) |-> 1'b0);

  // R11
  rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |-> (remR < magD));

endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       opSel,
  input  logic [WIDTH-1:0] tosA,
  input  logic [WIDTH-1:0] tosB,
  input  logic [WIDTH-1:0] tosC,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] resTop,
  output logic [WIDTH-1:0] resSecond,
  output logic             ovf,
  output logic             divZero
);

  mduStrobe_t stb;
  logic       dvsZero;
  logic       earlyOvf;

  mdu_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opIn     (mduOp_e'(opSel)),
    .dvsZero  (dvsZero),
    .earlyOvf (earlyOvf),
    .stb      (stb),
    .busy     (busy),
    .done     (done)
  );

  mdu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .tosA      (tosA),
    .tosB      (tosB),
    .tosC      (tosC),
    .dvsZero   (dvsZero),
    .earlyOvf  (earlyOvf),
    .resTop    (resTop),
    .resSecond (resSecond),
    .ovf       (ovf),
    .divZero   (divZero)
  );

endmodule

// File: tb/sim_mdu_top.sv
module sim_mdu_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int LIM        = 190000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   opSel = 2'd0;
  logic [W-1:0] tosA = '0, tosB = '0, tosC = '0;
  logic         busy, done, ovf, divZero;
  logic [W-1:0] resTop, resSecond;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  mdu_top #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .tosA(tosA), .tosB(tosB), .tosC(tosC),
    .busy(busy), .done(done), .resTop(resTop), .resSecond(resSecond),
    .ovf(ovf), .divZero(divZero)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > LIM && !finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cycles, LIM);
      summary();
    end
  end

  function automatic longint sx(input longint v, input int n);
    longint half = longint'(1) <<< (n - 1);
    return (v >= half) ? v - (longint'(1) <<< n) : v;
  endfunction

  function automatic longint mag(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs one operation and compares against a reference computed here.
  task automatic runOp(input int opv, input int a, input int b, input int c);
    longint mask  = (longint'(1) <<< W) - 1;
    longint lo    = -(longint'(1) <<< (W - 1));
    longint hi    = (longint'(1) <<< (W - 1)) - 1;
    longint eTop = 0, eSec = 0, p, n, d, q, r;
    bit     eOvf = 0, eDz = 0;
    int     eLat;
    int     k;
    bit     busyBad = 0;
    string  tag;

    eLat = 2;
    d = sx(a, W);
    if (opv == 0) begin
      tag = "R6 short mul";
      p = sx(a, W) * sx(b, W);
      eTop = p & mask;
      eOvf = (p < lo) || (p > hi);
    end else if (opv == 1) begin
      tag = "R7 long mul";
      p = sx(a, W) * sx(b, W);
      eTop = p & mask;
      eSec = (p >>> W) & mask;
    end else begin
      if (opv == 2) n = sx((longint'(c) <<< W) + b, 2 * W);
      else          n = sx(b, W);
      if (d == 0) begin
        tag = "R8 zero divisor";
        eDz = 1;
      end else if (opv == 2 && mag(d) <= mag(sx(c, W))) begin
        tag = "R10 early long overflow";
        eOvf = 1;
      end else begin
        eLat = 2 * W + 3;
        q = n / d;
        r = n % d;
        eTop = q & mask;
        eSec = r & mask;
        eOvf = (q < lo) || (q > hi);
        if (eOvf)          tag = "R11 quotient range";
        else if (opv == 2) tag = "R9 long divide";
        else               tag = "R12 short divide";
      end
    end

    @(negedge clk);
    start = 1'b1;
    opSel = 2'(opv);
    tosA = W'(a);
    tosB = W'(b);
    tosC = W'(c);
    k = 0;
    while (1) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        // R2: a second start and scrambled operands while busy
        start = 1'b1;
        opSel = 2'(opv ^ 1);
        tosA = ~W'(a);
        tosB = ~W'(b);
        tosC = ~W'(c);
      end else begin
        start = 1'b0;
      end
      if (!busy) busyBad = 1;
      if (done || k > 60) break;
    end
    start = 1'b0;
    check({tag, " R2 R5 result words"}, {resSecond, resTop}, (eSec << W) | eTop);
    check({tag, " flags"}, {ovf, divZero}, {eOvf, eDz});
    check("R4 latency", k, eLat);
    check("R3 busy held through done", busyBad, 0);
    @(negedge clk);
    check("R3 done single pulse, busy released", {done, busy}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {busy, done, ovf, divZero, resTop, resSecond}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {busy, done}, 0);

    for (int op = 0; op < 2; op++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          runOp(op, a, b, 0);
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        runOp(3, a, b, a ^ b);
    for (int c = 0; c < (1 << W); c++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          runOp(2, a, b, c);

    if (!finished) begin
      finished = 1'b1;
      summary();
    end
  end

endmodule